// File: doc/BRIEF.md
# Randomized-Order Boolean Network Emulator

This block runs an eight-node Boolean regulatory network in clocked hardware. It keeps the asynchronous character of such networks by recomputing one node at a time, never all at once. Each node holds a single state bit. Its next value comes from a fixed logic rule over the current state vector and two external stimulus lines. A knockout mask can pin any node to zero.

Before each round, a pseudo-random shuffle reorders the node visiting sequence. A 16-bit linear feedback shift register drives that shuffle. A round then visits each node exactly once, in the shuffled order, and each update is written in place. After the programmed number of rounds, the block offers the final state on a valid/ready result port. It then reloads the initial state and starts the next simulation, until the programmed number of simulations is done.

A single `start` pulse captures the seed, the round and simulation counts and the initial state. The block then runs with no further intervention. Back-pressure on the result port stalls the whole emulation: while `res_valid` is high and `res_ready` is low, the block does no further work and the offered state does not move. A one-cycle `done` pulse ends the run.

Top module: `bnet_emu`

## Requirements
- R1: Node rules, with s the current state and x the stimulus: n0=x[0], n1=s0&~s7, n2=s1|s3, n3=s2&~x[1], n4=s1&s2, n5=~s4|s6, n6=s5&s3, n7=s4|(s6&~s0); bit i of `res_state` is node i.
- R2: When bit i of `knockout` is high as node i is evaluated, node i is written as 0 whatever its rule gives.
- R3: The visiting order is a permutation held across rounds, set to the identity (position p holds node p) when a start is accepted. Before each round it is reshuffled in 7 cycles. In each of those cycles, for h = 7 down to 1, position h swaps with position j = (L[7:0]*(h+1))>>8, where L is the current LFSR value. Every node is updated exactly once per round.
- R4: The LFSR shifts left, with new bit 0 = L15^L13^L12^L10. It is loaded on an accepted start from `cfg_seed`, or with 1 if the seed is 0. It advances only in shuffle cycles and is not reloaded between simulations.
- R5: An update reads the live state, including nodes already updated earlier in the same round. `stim` and `knockout` are sampled in the node's evaluation cycle.
- R6: Each node update takes four cycles: select, evaluate, write, advance. A round therefore costs 7+32 cycles.
- R7: After `cfg_rounds` rounds the state is offered on the result port. With `cfg_rounds`=0 the initial state is offered unchanged.
- R8: `cfg_sims` results are produced, each simulation restarting from the captured initial state. With `cfg_sims`=0 the block goes straight to `done` without offering a result.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_state` stays unchanged.
- R10: `done` is high for exactly one cycle, the cycle after the last result handshake, and the block is idle in the next cycle.
- R11: `busy` is high from the cycle after an accepted start through the `done` cycle. `start` while busy is ignored.
- R12: After reset, `busy`, `done` and `res_valid` are low and `res_state` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| cfg_seed | input | 16 | LFSR seed captured at start |
| cfg_rounds | input | ROUND_W (8) | Rounds per simulation |
| cfg_sims | input | SIM_W (10) | Number of simulations |
| init_state | input | 8 | Initial node states |
| stim | input | 2 | Live external stimuli |
| knockout | input | 8 | Live per-node force-to-zero mask |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| res_valid | output | 1 | Final state offered |
| res_ready | input | 1 | Consumer accepts the final state |
| res_state | output | 8 | Final node states |

## Verification
A corrupted visiting order or LFSR value does not show up at once. It changes which neighbour values each later update reads, so `res_state` parts from the expected value at the first result whose trajectory depends on it. That is at most one simulation later, and usually within the same round. Because the bench model follows the phase sequence clock by clock, a wrong phase counter or round counter shows up within one cycle on `busy`, `res_valid` or `done`. The knockout, zero-round and zero-simulation cases show up directly in the offered state and in the handshake count.

// File: rtl/bnet_pkg.sv
package bnet_pkg;
  localparam int N_NODES = 8;
  localparam int IDX_W   = $clog2(N_NODES);
  localparam int STIM_W  = 2;
  localparam int LFSR_W  = 16;
  localparam int PICK_W  = 8;

  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [N_NODES-1:0] nvec_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SHUF, PH_SEL, PH_EVAL, PH_WB, PH_ADV, PH_OUT, PH_FIN
  } phase_e;
endpackage

// File: rtl/bnet_lfsr.sv
module bnet_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign value = q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= W'(1);
    else if (load) q <= (seed == '0) ? W'(1) : seed;
    else if (step) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/bnet_rules.sv
module bnet_rules
  import bnet_pkg::*;
(
  input  idx_t              node,
  input  nvec_t             cur,
  input  logic [STIM_W-1:0] stim,
  input  nvec_t             ko,
  output logic              nxt
);
  logic raw;

  always_comb begin
    case (node)
      idx_t'(0): raw = stim[0];
      idx_t'(1): raw = cur[0] & ~cur[7];
      idx_t'(2): raw = cur[1] | cur[3];
      idx_t'(3): raw = cur[2] & ~stim[1];
      idx_t'(4): raw = cur[1] & cur[2];
      idx_t'(5): raw = ~cur[4] | cur[6];
      idx_t'(6): raw = cur[5] & cur[3];
      default:   raw = cur[4] | (cur[6] & ~cur[0]);
    endcase
    nxt = raw & ~ko[node];
  end
endmodule

// File: rtl/bnet_order.sv
module bnet_order
  import bnet_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              swap_en,
  input  idx_t              hi,
  input  logic [PICK_W-1:0] pick,
  input  idx_t              rd_pos,
  output idx_t              rd_node,
  output logic [N_NODES*IDX_W-1:0] perm_flat
);
  localparam int PROD_W = PICK_W + IDX_W + 1;

  idx_t perm_q [N_NODES];
  logic [PROD_W-1:0] prod;
  idx_t lo;

  assign prod    = PROD_W'(pick) * (PROD_W'(hi) + PROD_W'(1));
  assign lo      = idx_t'(prod >> PICK_W);
  assign rd_node = perm_q[rd_pos];

  for (genvar p = 0; p < N_NODES; p++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || init) perm_q[p] <= idx_t'(p);
      else if (swap_en) begin
        if (idx_t'(p) == hi)      perm_q[p] <= perm_q[lo];
        else if (idx_t'(p) == lo) perm_q[p] <= perm_q[hi];
      end
    end
    assign perm_flat[p*IDX_W +: IDX_W] = perm_q[p];
  end
endmodule

// File: rtl/bnet_emu.sv
module bnet_emu
  import bnet_pkg::*;
#(
  parameter int ROUND_W = 8,
  parameter int SIM_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LFSR_W-1:0]  cfg_seed,
  input  logic [ROUND_W-1:0] cfg_rounds,
  input  logic [SIM_W-1:0]   cfg_sims,
  input  logic [N_NODES-1:0] init_state,
  input  logic [STIM_W-1:0]  stim,
  input  logic [N_NODES-1:0] knockout,
  output logic               busy,
  output logic               done,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [N_NODES-1:0] res_state
);
  localparam idx_t LAST = idx_t'(N_NODES - 1);

  phase_e             ph_q;
  nvec_t              state_q, init_q;
  idx_t               shuf_q, step_q, node_q;
  logic               nb_q;
  logic [ROUND_W-1:0] rounds_q, rnd_q;
  logic [SIM_W-1:0]   sims_q, sim_q;

  logic               accept;
  logic [LFSR_W-1:0]  lfsr_q;
  idx_t               rd_node;
  logic               rule_bit;
  logic [N_NODES*IDX_W-1:0] perm_flat;
  logic               wb_fire, eval_fire, round_end;

  assign accept    = (ph_q == PH_IDLE) && start;
  assign wb_fire   = (ph_q == PH_WB);
  assign eval_fire = (ph_q == PH_EVAL);
  assign round_end = (ph_q == PH_ADV) && (step_q == LAST);

  bnet_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(accept), .seed(cfg_seed),
    .step(ph_q == PH_SHUF), .value(lfsr_q)
  );

  bnet_order u_order (
    .clk(clk), .rst_n(rst_n), .init(accept), .swap_en(ph_q == PH_SHUF),
    .hi(shuf_q), .pick(lfsr_q[PICK_W-1:0]), .rd_pos(step_q),
    .rd_node(rd_node), .perm_flat(perm_flat)
  );

  bnet_rules u_rules (
    .node(node_q), .cur(state_q), .stim(stim), .ko(knockout), .nxt(rule_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      state_q  <= '0;
      init_q   <= '0;
      shuf_q   <= LAST;
      step_q   <= '0;
      node_q   <= '0;
      nb_q     <= 1'b0;
      rounds_q <= '0;
      rnd_q    <= '0;
      sims_q   <= '0;
      sim_q    <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          init_q   <= init_state;
          state_q  <= init_state;
          rounds_q <= cfg_rounds;
          sims_q   <= cfg_sims;
          rnd_q    <= '0;
          sim_q    <= '0;
          shuf_q   <= LAST;
          step_q   <= '0;
          if (cfg_sims == '0)        ph_q <= PH_FIN;
          else if (cfg_rounds == '0) ph_q <= PH_OUT;
          else                       ph_q <= PH_SHUF;
        end
        PH_SHUF: begin
          if (shuf_q == idx_t'(1)) begin
            step_q <= '0;
            ph_q   <= PH_SEL;
          end else begin
            shuf_q <= shuf_q - idx_t'(1);
          end
        end
        PH_SEL: begin
          node_q <= rd_node;
          ph_q   <= PH_EVAL;
        end
        PH_EVAL: begin
          nb_q <= rule_bit;
          ph_q <= PH_WB;
        end
        PH_WB: begin
          state_q[node_q] <= nb_q;
          ph_q            <= PH_ADV;
        end
        PH_ADV: begin
          if (step_q == LAST) begin
            step_q <= '0;
            shuf_q <= LAST;
            rnd_q  <= rnd_q + ROUND_W'(1);
            ph_q   <= ((rnd_q + ROUND_W'(1)) == rounds_q) ? PH_OUT : PH_SHUF;
          end else begin
            step_q <= step_q + idx_t'(1);
            ph_q   <= PH_SEL;
          end
        end
        PH_OUT: if (res_ready) begin
          if ((sim_q + SIM_W'(1)) == sims_q) begin
            ph_q <= PH_FIN;
          end else begin
            sim_q   <= sim_q + SIM_W'(1);
            state_q <= init_q;
            rnd_q   <= '0;
            shuf_q  <= LAST;
            ph_q    <= (rounds_q == '0) ? PH_OUT : PH_SHUF;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign done      = (ph_q == PH_FIN);
  assign res_valid = (ph_q == PH_OUT);
  assign res_state = state_q;
endmodule

// File: rtl/bnet_emu_chk.sv
module bnet_emu_chk
  import bnet_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               res_valid,
  input logic               res_ready,
  input logic [N_NODES-1:0] res_state,
  input logic [N_NODES-1:0] knockout,
  input logic [LFSR_W-1:0]  lfsr_val,
  input logic [N_NODES*IDX_W-1:0] perm_flat,
  input logic               wb_fire,
  input logic               eval_fire,
  input logic               round_end,
  input logic [IDX_W-1:0]   node_q
);
  nvec_t seen_q;
  nvec_t cover_mask;
  logic  ko_pend_q;

  always_comb begin
    cover_mask = '0;
    for (int p = 0; p < N_NODES; p++)
      cover_mask[perm_flat[p*IDX_W +: IDX_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || round_end) seen_q <= '0;
    else if (wb_fire)                 seen_q[node_q] <= 1'b1;
    ko_pend_q <= rst_n && eval_fire && knockout[node_q];
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_state)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_idle_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_val != '0);

  assert_perm_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    &cover_mask);

  assert_single_visit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> !seen_q[node_q]);

  assert_round_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
    round_end |-> &seen_q);

  assert_knockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ko_pend_q && wb_fire) |=> !res_state[node_q]);
endmodule

bind bnet_emu bnet_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .res_valid(res_valid), .res_ready(res_ready), .res_state(res_state),
  .knockout(knockout), .lfsr_val(lfsr_q), .perm_flat(perm_flat),
  .wb_fire(wb_fire), .eval_fire(eval_fire), .round_end(round_end),
  .node_q(node_q)
);

// File: tb/bnet_emu_test.sv
module bnet_emu_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg_seed = '0;
  logic [7:0]  cfg_rounds = '0;
  logic [9:0]  cfg_sims = '0;
  logic [7:0]  init_state = '0;
  logic [1:0]  stim = '0;
  logic [7:0]  knockout = '0;
  logic        busy, done, res_valid;
  logic        res_ready = 1'b1;
  logic [7:0]  res_state;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int n_res = 0;
  bit ko2_watch = 1'b0;
  bit run_on = 1'b0;

  bnet_emu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_seed(cfg_seed),
    .cfg_rounds(cfg_rounds), .cfg_sims(cfg_sims), .init_state(init_state),
    .stim(stim), .knockout(knockout), .busy(busy), .done(done),
    .res_valid(res_valid), .res_ready(res_ready), .res_state(res_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: phases 0 idle,1 shuffle,2 select,3 evaluate,4 write,5 advance,6 offer,7 finish
  int        m_ph;
  bit [7:0]  m_st, m_init;
  int        m_perm [8];
  bit [15:0] m_lfsr;
  int        m_i, m_k, m_node, m_rounds, m_sims, m_rnd, m_sim;
  bit        m_nb;

  function automatic bit rule_of(int n, bit [7:0] s, bit [1:0] x, bit [7:0] ko);
    bit r;
    case (n)
      0: r = x[0];
      1: r = s[0] & ~s[7];
      2: r = s[1] | s[3];
      3: r = s[2] & ~x[1];
      4: r = s[1] & s[2];
      5: r = ~s[4] | s[6];
      6: r = s[5] & s[3];
      default: r = s[4] | (s[6] & ~s[0]);
    endcase
    return r & ~ko[n];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_st = 0; m_init = 0; m_lfsr = 16'd1;
      m_i = 7; m_k = 0; m_node = 0; m_nb = 0;
      m_rounds = 0; m_sims = 0; m_rnd = 0; m_sim = 0;
      for (int p = 0; p < 8; p++) m_perm[p] = p;
    end else begin
      case (m_ph)
        0: if (start) begin
          m_init = init_state; m_st = init_state;
          m_rounds = cfg_rounds; m_sims = cfg_sims;
          m_lfsr = (cfg_seed == 0) ? 16'd1 : cfg_seed;
          for (int p = 0; p < 8; p++) m_perm[p] = p;
          m_rnd = 0; m_sim = 0; m_i = 7; m_k = 0;
          m_ph = (m_sims == 0) ? 7 : (m_rounds == 0) ? 6 : 1;
        end
        1: begin
          int j, t;
          j = (int'(m_lfsr[7:0]) * (m_i + 1)) >> 8;
          t = m_perm[m_i]; m_perm[m_i] = m_perm[j]; m_perm[j] = t;
          m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
          if (m_i == 1) begin m_ph = 2; m_k = 0; end
          else m_i--;
        end
        2: begin m_node = m_perm[m_k]; m_ph = 3; end
        3: begin m_nb = rule_of(m_node, m_st, stim, knockout); m_ph = 4; end
        4: begin m_st[m_node] = m_nb; m_ph = 5; end
        5: begin
          if (m_k == 7) begin
            m_k = 0; m_i = 7; m_rnd++;
            m_ph = (m_rnd == m_rounds) ? 6 : 1;
          end else begin
            m_k++; m_ph = 2;
          end
        end
        6: if (res_ready) begin
          n_res++;
          if (m_sim + 1 == m_sims) m_ph = 7;
          else begin
            m_sim++; m_st = m_init; m_rnd = 0; m_i = 7;
            m_ph = (m_rounds == 0) ? 6 : 1;
          end
        end
        default: m_ph = 0;
      endcase
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_on) begin
      chk(busy == (m_ph != 0), "R11", "busy", busy, m_ph != 0);
      chk(done == (m_ph == 7), "R10", "done", done, m_ph == 7);
      chk(res_valid == (m_ph == 6), "R6", "res_valid", res_valid, m_ph == 6);
      chk(res_state == m_st, "R1", "res_state", res_state, m_st);
      if (ko2_watch && res_valid)
        chk(res_state[2] == 1'b0, "R2", "knocked-out node 2", res_state[2], 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // mode: 0 always ready, 1 throttled ready; flip_at: cycle to raise stim[1]; poke: start while busy
  task automatic run(input bit [15:0] seed, input int rounds, input int sims,
                     input bit [7:0] init, input bit [1:0] x, input bit [7:0] ko,
                     input int mode, input int flip_at, input bit poke,
                     input string req);
    int c;
    @(negedge clk);
    cfg_seed = seed; cfg_rounds = rounds[7:0]; cfg_sims = sims[9:0];
    init_state = init; stim = x; knockout = ko; res_ready = 1'b1;
    n_res = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (!done) begin
      c++;
      if (mode == 1) res_ready = (c % 3 == 0);
      if (c == flip_at) stim = x ^ 2'b10;
      if (poke && c == 20) begin start = 1'b1; init_state = 8'hFF; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    res_ready = 1'b1;
    chk(n_res == sims, req, "result count", n_res, sims);
    @(negedge clk);
    chk(!busy, "R10", "idle after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R12", "busy at reset", busy, 0);
    chk(done == 0, "R12", "done at reset", done, 0);
    chk(res_valid == 0, "R12", "res_valid at reset", res_valid, 0);
    chk(res_state == 0, "R12", "res_state at reset", res_state, 0);
    rst_n = 1'b1;
    run_on = 1'b1;
    @(negedge clk);

    // R1 R3 R5 R6: plain run, stimulus change mid-run
    run(16'hACE1, 3, 2, 8'h00, 2'b01, 8'h00, 0, 50, 1'b0, "R8");
    // R2 R4 R9 R11: zero seed, knockout of node 2, throttled consumer, stray start
    ko2_watch = 1'b1;
    run(16'h0000, 2, 3, 8'h5A, 2'b01, 8'h04, 1, 70, 1'b1, "R8");
    ko2_watch = 1'b0;
    // R7: zero rounds gives back the initial state
    @(negedge clk);
    cfg_seed = 16'h1234; cfg_rounds = 0; cfg_sims = 2; init_state = 8'hA5;
    res_ready = 1'b0; n_res = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(res_valid == 1'b1, "R7", "valid with zero rounds", res_valid, 1);
    chk(res_state == 8'hA5, "R7", "state with zero rounds", res_state, 8'hA5);
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_state == 8'hA5, "R7", "second sim state", res_state, 8'hA5);
    @(negedge clk);
    chk(done == 1'b1, "R10", "done after last result", done, 1);
    chk(n_res == 2, "R8", "zero-round result count", n_res, 2);
    @(negedge clk);
    // R8: zero simulations
    cfg_sims = 0; cfg_rounds = 4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && res_valid == 1'b0, "R8", "zero sims ends at once",
        {done, res_valid}, 2'b10);
    @(negedge clk);
    // Long run toward steady state
    run(16'hBEEF, 16, 4, 8'h81, 2'b11, 8'h00, 1, 400, 1'b0, "R8");
    run(16'h7001, 5, 3, 8'hFF, 2'b00, 8'h10, 0, 90, 1'b0, "R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule